// File: doc/BRIEF.md
# Filtered Input Capture Unit

This block watches one external input and captures the value of a running counter when a chosen edge of that input arrives. The input is first brought into the clock domain by a two-flop synchronizer. It can then be inverted, and it passes through a digital glitch filter. The filter has a sample period setting and an agreement count setting, and a period of zero bypasses it. The clean signal goes to an edge detector. On a qualifying edge, the unit stores the counter value presented on `cnt_in` into a capture register and sets an edge flag.

The counter itself lives outside the block. When reload-on-capture is enabled, the unit sends that counter a one-cycle reload pulse in the capture cycle. Each capture then holds the time elapsed since the previous one, which measures the input period directly. The edge flag drives either an interrupt line or a DMA request line. Their two enables exclude each other. The unit also owns the pin's output enable, which is dropped whenever the pin is placed in a capture mode.

Top module: `fcap_top`

## Requirements
- R1: With the filter bypassed (period 0), a pin change made before rising edge E1 sets the edge flag at rising edge E4 and not at E3. The path is two synchronizer flops, one filter register and one edge register.
- R2: When `cfg_invert` is 1, the synchronized input is inverted before filtering and edge detection, so a falling pin edge counts as a rising edge.
- R3: `cfg_edge_mode` selects the edges as follows: 2'b00 selects none, 2'b01 rising, 2'b10 falling and 2'b11 both.
- R4: On a qualifying edge, `cap_value` takes the `cnt_in` value present in the detection cycle, and `edge_flag` is set at the same clock edge.
- R5: With `cfg_reload_en` set, `cnt_reload` pulses for one cycle per capture, so successive captures read the input period minus one. With it clear, `cnt_reload` never pulses.
- R6: With a nonzero filter period P, the filter samples once every P+1 clocks. Its output follows a new level only after C+3 consecutive samples disagree with it, where C is `cfg_filt_count`. Shorter glitches are discarded.
- R7: `flag_clr` is a write-one-to-clear strobe for the edge flag. A capture in the same cycle takes priority and leaves the flag set.
- R8: `irq_en_set` sets the interrupt enable and clears the DMA enable. `dma_en_set` sets the DMA enable and clears the interrupt enable. When both strobes arrive in one cycle, nothing changes. The `*_clr` strobes clear their own enable when no lone set strobe is present.
- R9: `irq` is the edge flag gated by the interrupt enable, and `dma_req` is the edge flag gated by the DMA enable.
- R10: `oe_set` sets `oe` only while the edge mode is 2'b00. Any nonzero edge mode clears `oe` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous external input |
| cnt_in | input | 16 | Running counter value |
| cfg_invert | input | 1 | Invert input polarity |
| cfg_edge_mode | input | 2 | Edge select: 00 off, 01 rise, 10 fall, 11 both |
| cfg_filt_count | input | 3 | Filter agreement count C (needs C+3 samples) |
| cfg_filt_period | input | 8 | Filter sample period P (0 = bypass) |
| cfg_reload_en | input | 1 | Request counter reload on capture |
| flag_clr | input | 1 | Write-one-to-clear strobe for the edge flag |
| irq_en_set | input | 1 | Set interrupt enable, clear DMA enable |
| irq_en_clr | input | 1 | Clear interrupt enable |
| dma_en_set | input | 1 | Set DMA enable, clear interrupt enable |
| dma_en_clr | input | 1 | Clear DMA enable |
| oe_set | input | 1 | Set pin output enable (only in mode 00) |
| cap_value | output | 16 | Captured counter value |
| edge_flag | output | 1 | Input edge flag |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| cnt_reload | output | 1 | One-cycle reload pulse to the counter |
| irq_en | output | 1 | Interrupt enable state |
| dma_en | output | 1 | DMA enable state |
| oe | output | 1 | Pin output enable |

## Verification
The hardest case to reach is a filter that has started counting agreeing samples and then sees the input return to its old level before the threshold. The stimulus produces this with pulses narrower than (C+3)·(P+1) clocks and checks that no flag appears. It then sends pulses well beyond that width and checks that they are accepted. A second hard case is a flag clear that lands in the very cycle a capture is detected. The bench reaches it by timing the strobe from the known R1 latency.

// File: rtl/fcap_pkg.sv
package fcap_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    // Qualifies a transition of the clean input against the selected mode.
    function automatic logic edge_qualifies(edge_mode_e mode, logic cur, logic prev);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        case (mode)
            EDGE_RISE: return rise;
            EDGE_FALL: return fall;
            EDGE_BOTH: return rise | fall;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fcap_filter.sv
module fcap_filter #(
    parameter int FCNT_W = 3,
    parameter int FPER_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_in,
    input  logic              invert,
    input  logic [FCNT_W-1:0] filt_count,
    input  logic [FPER_W-1:0] filt_period,
    output logic              clean
);
    localparam int AGREE_W = $clog2((1 << FCNT_W) + 3);

    logic [1:0]         sync_q;
    logic               sampled;
    logic               bypass;
    logic               tick;
    logic [FPER_W-1:0]  presc_q;
    logic [AGREE_W-1:0] agree_q;
    logic [AGREE_W-1:0] thresh;
    logic               clean_q;

    assign sampled = sync_q[1] ^ invert;
    assign bypass  = (filt_period == '0);
    assign tick    = (presc_q == filt_period);
    assign thresh  = AGREE_W'(filt_count) + AGREE_W'(2);
    assign clean   = clean_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[0], pin_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            presc_q <= '0;
            agree_q <= '0;
            clean_q <= 1'b0;
        end else if (bypass) begin
            presc_q <= '0;
            agree_q <= '0;
            clean_q <= sampled;
        end else begin
            presc_q <= tick ? '0 : presc_q + 1'b1;
            if (tick) begin
                if (sampled == clean_q) begin
                    agree_q <= '0;
                end else if (agree_q == thresh) begin
                    clean_q <= sampled;
                    agree_q <= '0;
                end else begin
                    agree_q <= agree_q + 1'b1;
                end
            end
        end
    end

    // R6: with filtering active the output only moves on a sample tick
    assert_filt_tick_R6: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !$past(bypass) && !$past(rst) && (clean_q != $past(clean_q))) |-> $past(tick));

    // R1: in bypass the output follows the synchronized sample one clock later
    assert_bypass_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(bypass) && !$past(rst)) |-> (clean_q == $past(sampled)));

endmodule

// File: rtl/fcap_latch.sv
module fcap_latch
    import fcap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clean,
    input  logic [1:0]       edge_mode,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             reload_en,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_value,
    output logic             edge_flag,
    output logic             cnt_reload
);
    logic             prev_q;
    logic             hit;
    logic [CNT_W-1:0] cap_q;
    logic             flag_q;

    assign hit        = edge_qualifies(edge_mode_e'(edge_mode), clean, prev_q);
    assign cnt_reload = hit & reload_en;
    assign cap_value  = cap_q;
    assign edge_flag  = flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            cap_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= clean;
            if (hit) begin
                cap_q  <= cnt_in;
                flag_q <= 1'b1;
            end else if (flag_clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
        hit |=> (edge_flag && cap_value == $past(cnt_in)));

    assert_w1c_R7: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !hit) |=> !edge_flag);

    assert_reload_flag_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_reload |=> edge_flag);

endmodule

// File: rtl/fcap_req.sv
module fcap_req (
    input  logic clk,
    input  logic rst,
    input  logic flag,
    input  logic mode_on,
    input  logic irq_en_set,
    input  logic irq_en_clr,
    input  logic dma_en_set,
    input  logic dma_en_clr,
    input  logic oe_set,
    output logic irq,
    output logic dma_req,
    output logic irq_en,
    output logic dma_en,
    output logic oe
);
    logic irq_en_q;
    logic dma_en_q;
    logic oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en_q <= 1'b0;
            dma_en_q <= 1'b0;
        end else if (irq_en_set ^ dma_en_set) begin
            irq_en_q <= irq_en_set;
            dma_en_q <= dma_en_set;
        end else begin
            if (irq_en_clr) irq_en_q <= 1'b0;
            if (dma_en_clr) dma_en_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          oe_q <= 1'b0;
        else if (mode_on) oe_q <= 1'b0;
        else if (oe_set)  oe_q <= 1'b1;
    end

    assign irq_en  = irq_en_q;
    assign dma_en  = dma_en_q;
    assign oe      = oe_q;
    assign irq     = flag & irq_en_q;
    assign dma_req = flag & dma_en_q;

    assert_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(irq_en && dma_en));

    assert_excl_req_R9: assert property (@(posedge clk) disable iff (rst)
        !(irq && dma_req));

    assert_oe_drop_R10: assert property (@(posedge clk) disable iff (rst)
        mode_on |=> !oe);

endmodule

// File: rtl/fcap_top.sv
module fcap_top #(
    parameter int CNT_W  = 16,
    parameter int FCNT_W = 3,
    parameter int FPER_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_in,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              cfg_invert,
    input  logic [1:0]        cfg_edge_mode,
    input  logic [FCNT_W-1:0] cfg_filt_count,
    input  logic [FPER_W-1:0] cfg_filt_period,
    input  logic              cfg_reload_en,
    input  logic              flag_clr,
    input  logic              irq_en_set,
    input  logic              irq_en_clr,
    input  logic              dma_en_set,
    input  logic              dma_en_clr,
    input  logic              oe_set,
    output logic [CNT_W-1:0]  cap_value,
    output logic              edge_flag,
    output logic              irq,
    output logic              dma_req,
    output logic              cnt_reload,
    output logic              irq_en,
    output logic              dma_en,
    output logic              oe
);
    logic clean;
    logic mode_on;

    assign mode_on = (cfg_edge_mode != 2'b00);

    fcap_filter #(.FCNT_W(FCNT_W), .FPER_W(FPER_W)) u_filter (
        .clk         (clk),
        .rst         (rst),
        .pin_in      (pin_in),
        .invert      (cfg_invert),
        .filt_count  (cfg_filt_count),
        .filt_period (cfg_filt_period),
        .clean       (clean)
    );

    fcap_latch #(.CNT_W(CNT_W)) u_latch (
        .clk        (clk),
        .rst        (rst),
        .clean      (clean),
        .edge_mode  (cfg_edge_mode),
        .cnt_in     (cnt_in),
        .reload_en  (cfg_reload_en),
        .flag_clr   (flag_clr),
        .cap_value  (cap_value),
        .edge_flag  (edge_flag),
        .cnt_reload (cnt_reload)
    );

    fcap_req u_req (
        .clk        (clk),
        .rst        (rst),
        .flag       (edge_flag),
        .mode_on    (mode_on),
        .irq_en_set (irq_en_set),
        .irq_en_clr (irq_en_clr),
        .dma_en_set (dma_en_set),
        .dma_en_clr (dma_en_clr),
        .oe_set     (oe_set),
        .irq        (irq),
        .dma_req    (dma_req),
        .irq_en     (irq_en),
        .dma_en     (dma_en),
        .oe         (oe)
    );

endmodule

// File: tb/fcap_top_test.sv
module fcap_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin_in = 1'b0;
    logic [15:0] cnt;
    logic        cfg_invert = 1'b0;
    logic [1:0]  cfg_edge_mode = 2'b00;
    logic [2:0]  cfg_filt_count = 3'd0;
    logic [7:0]  cfg_filt_period = 8'd0;
    logic        cfg_reload_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic        irq_en_set = 1'b0, irq_en_clr = 1'b0;
    logic        dma_en_set = 1'b0, dma_en_clr = 1'b0;
    logic        oe_set = 1'b0;
    logic [15:0] cap_value;
    logic        edge_flag, irq, dma_req, cnt_reload, irq_en, dma_en, oe;

    int applied = 0;
    int wrong = 0;
    int reloads = 0;

    always #4 clk = ~clk;

    // External counter model, reloaded by the unit
    always_ff @(posedge clk) begin
        if (rst || cnt_reload) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
        if (!rst && cnt_reload) reloads <= reloads + 1;
    end

    fcap_top uut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .cnt_in(cnt),
        .cfg_invert(cfg_invert), .cfg_edge_mode(cfg_edge_mode),
        .cfg_filt_count(cfg_filt_count), .cfg_filt_period(cfg_filt_period),
        .cfg_reload_en(cfg_reload_en), .flag_clr(flag_clr),
        .irq_en_set(irq_en_set), .irq_en_clr(irq_en_clr),
        .dma_en_set(dma_en_set), .dma_en_clr(dma_en_clr), .oe_set(oe_set),
        .cap_value(cap_value), .edge_flag(edge_flag), .irq(irq),
        .dma_req(dma_req), .cnt_reload(cnt_reload), .irq_en(irq_en),
        .dma_en(dma_en), .oe(oe)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            wrong++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
    endtask

    task automatic test_reset();
        chk("R4 reset flag", edge_flag, 0);
        chk("R4 reset cap", cap_value, 0);
        chk("R8 reset enables", {irq_en, dma_en}, 0);
        chk("R10 reset oe", oe, 0);
    endtask

    task automatic test_latency_capture();
        logic [15:0] seen;
        cfg_edge_mode = 2'b01;
        tick(6);
        clear_flag();
        pin_in = 1'b1;
        tick(3);
        chk("R1 flag not yet at E3", edge_flag, 0);
        seen = cnt;
        tick(1);
        chk("R1 flag at E4", edge_flag, 1);
        chk("R4 captured counter", cap_value, seen);
        pin_in = 1'b0;
        tick(6);
    endtask

    task automatic test_modes();
        logic [15:0] held;
        // R3 rising only: falling edge must not flag
        cfg_edge_mode = 2'b01;
        clear_flag();
        held = cap_value;
        pin_in = 1'b1; tick(6);
        chk("R3 rise mode rise", edge_flag, 1);
        clear_flag();
        held = cap_value;
        pin_in = 1'b0; tick(6);
        chk("R3 rise mode ignores fall", {edge_flag, cap_value}, {1'b0, held});
        // falling only
        cfg_edge_mode = 2'b10;
        pin_in = 1'b1; tick(6);
        chk("R3 fall mode ignores rise", edge_flag, 0);
        pin_in = 1'b0; tick(6);
        chk("R3 fall mode fall", edge_flag, 1);
        clear_flag();
        // both
        cfg_edge_mode = 2'b11;
        pin_in = 1'b1; tick(6);
        chk("R3 both mode rise", edge_flag, 1);
        clear_flag();
        pin_in = 1'b0; tick(6);
        chk("R3 both mode fall", edge_flag, 1);
        clear_flag();
        // disabled
        cfg_edge_mode = 2'b00;
        held = cap_value;
        pin_in = 1'b1; tick(6);
        pin_in = 1'b0; tick(6);
        chk("R3 off mode", {edge_flag, cap_value}, {1'b0, held});
    endtask

    task automatic test_invert();
        cfg_edge_mode = 2'b01;
        cfg_invert = 1'b1;   // clean signal goes high with pin low
        tick(6);
        clear_flag();
        pin_in = 1'b1; tick(6);
        chk("R2 inverted pin rise is a fall", edge_flag, 0);
        pin_in = 1'b0; tick(6);
        chk("R2 inverted pin fall is a rise", edge_flag, 1);
        cfg_invert = 1'b0;
        tick(6);
        clear_flag();
    endtask

    task automatic test_w1c();
        cfg_edge_mode = 2'b01;
        clear_flag();
        chk("R7 clear strobe", edge_flag, 0);
        pin_in = 1'b1;
        tick(3);
        flag_clr = 1'b1;     // lands in the detection cycle
        tick(1);
        flag_clr = 1'b0;
        chk("R7 capture beats clear", edge_flag, 1);
        clear_flag();
        chk("R7 clear after capture", edge_flag, 0);
        pin_in = 1'b0; tick(6);
    endtask

    task automatic test_reload();
        int r0;
        cfg_edge_mode = 2'b01;
        cfg_reload_en = 1'b1;
        tick(4);
        r0 = reloads;
        for (int i = 0; i < 3; i++) begin
            pin_in = 1'b1; tick(10);
            pin_in = 1'b0; tick(10);
        end
        chk("R5 period capture", cap_value, 19);
        chk("R5 one pulse per capture", reloads - r0, 3);
        cfg_reload_en = 1'b0;
        r0 = reloads;
        pin_in = 1'b1; tick(10);
        pin_in = 1'b0; tick(10);
        chk("R5 no pulse when off", reloads - r0, 0);
        clear_flag();
    endtask

    task automatic test_filter();
        cfg_edge_mode = 2'b01;
        cfg_filt_period = 8'd1;
        cfg_filt_count = 3'd0;
        tick(8);
        clear_flag();
        pin_in = 1'b1; tick(3);
        pin_in = 1'b0; tick(14);
        chk("R6 short glitch P1 C0", edge_flag, 0);
        pin_in = 1'b1; tick(30);
        chk("R6 long pulse P1 C0", edge_flag, 1);
        pin_in = 1'b0; tick(30);
        clear_flag();
        cfg_filt_period = 8'd3;
        cfg_filt_count = 3'd1;
        tick(8);
        pin_in = 1'b1; tick(10);
        pin_in = 1'b0; tick(30);
        chk("R6 short glitch P3 C1", edge_flag, 0);
        pin_in = 1'b1; tick(40);
        chk("R6 long pulse P3 C1", edge_flag, 1);
        pin_in = 1'b0; tick(40);
        clear_flag();
        cfg_filt_period = 8'd0;
        cfg_filt_count = 3'd0;
        tick(4);
    endtask

    task automatic test_enables();
        cfg_edge_mode = 2'b01;
        irq_en_set = 1'b1; tick(1); irq_en_set = 1'b0;
        chk("R8 irq set", {irq_en, dma_en}, 2'b10);
        dma_en_set = 1'b1; tick(1); dma_en_set = 1'b0;
        chk("R8 dma set clears irq", {irq_en, dma_en}, 2'b01);
        irq_en_set = 1'b1; dma_en_set = 1'b1; tick(1);
        irq_en_set = 1'b0; dma_en_set = 1'b0;
        chk("R8 both set ignored", {irq_en, dma_en}, 2'b01);
        pin_in = 1'b1; tick(6);
        chk("R9 dma request", {irq, dma_req}, 2'b01);
        irq_en_set = 1'b1; tick(1); irq_en_set = 1'b0;
        chk("R9 irq request", {irq, dma_req}, 2'b10);
        irq_en_clr = 1'b1; tick(1); irq_en_clr = 1'b0;
        chk("R8 clear strobe", {irq_en, dma_en, irq, dma_req}, 4'b0000);
        clear_flag();
        pin_in = 1'b0; tick(6);
    endtask

    task automatic test_oe();
        cfg_edge_mode = 2'b00;
        tick(1);
        oe_set = 1'b1; tick(1); oe_set = 1'b0;
        chk("R10 oe set in mode 00", oe, 1);
        cfg_edge_mode = 2'b10;
        tick(1);
        chk("R10 capture mode drops oe", oe, 0);
        oe_set = 1'b1; tick(1); oe_set = 1'b0;
        chk("R10 oe set ignored in capture", oe, 0);
        cfg_edge_mode = 2'b00;
        tick(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        wrong++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", applied, wrong);
        $finish;
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(1);
        test_reset();
        test_latency_capture();
        test_modes();
        test_invert();
        test_w1c();
        test_reload();
        test_filter();
        test_enables();
        test_oe();
        $display("== %0d vectors applied, %0d miscompares ==", applied, wrong);
        $finish;
    end
endmodule